// File: doc/BRIEF.md
# Parallel ADC Bus Interface Controller

This block is the master of a 16-bit parallel bus to a simultaneous-sampling analog-to-digital converter. It has two jobs. The first is to collect results. The converter raises its busy line while it converts. When busy drops, the block runs a burst of read cycles under one chip-select window. The burst returns the results as A/B pairs, and the block spreads them across per-channel output words. A one-cycle valid pulse marks the end of the burst.

The second job is to reach the converter's internal configuration registers over the same bus. A two-bit request input asks for a register write or a register read. The block runs one access cycle and signals when it has finished.

The strobe low and high phases each last a parameterised number of clock cycles. This gives the converter its setup and hold margin. The bus appears as separate input, output and release (high-impedance) signals, so that a pad ring can join them.

Top module: `pbus_adc_ctrl`

## Requirements
- R1: After reset, csN, rdN and wrN are high, dbHiZ is high, and dataValid, overflow and accDone are low.
- R2: A result burst starts only after busyIn goes from 1 to 0. While busyIn stays high, or when it rises, no read strobe is issued.
- R3: During a burst, csN stays low for the whole burst, so there is exactly one csN rising edge per burst. Each word gets its own rdN low pulse. The pulse is STROBE_CYC clocks low, then STROBE_CYC clocks high. rdN and wrN are never low together, and neither strobe is low unless csN is low.
- R4: The number of words read equals burstLen, clamped to NUM_CH. Word k is sampled from dbIn at the rising edge of rdN and lands in chData[16k+15:16k]. The A result of pair j goes to channel 2j and the B result to channel 2j+1.
- R5: After the last word of a burst, csN returns high and dataValid pulses for exactly one cycle. chEnable[i] is 1 exactly when i is less than the length of the last burst.
- R6: A burst length of 0 produces no read strobe and no dataValid pulse.
- R7: A write request (accReq bit 0 = 1) runs one write cycle. csN and wrN go low together for STROBE_CYC clocks, with regWrData driven on dbOut and dbHiZ low. Then both return high for STROBE_CYC clocks, and accDone pulses once.
- R8: A read request (accReq bit 1 = 1, bit 0 = 0) runs one read cycle. csN and rdN go low with the bus released. The value on dbIn at the rdN rising edge appears on regRdData, and accDone pulses once.
- R9: When both request bits are set, only the write is performed.
- R10: A request raised while a burst is active or pending is ignored. No write or read access strobe follows it, and accDone does not pulse.
- R11: A busyIn falling edge during an active burst pulses overflow for one cycle. The running burst completes with its original word order, and the extra edge starts no second burst.
- R12: A busyIn falling edge during a register access does not interrupt the access. The burst runs after the access completes, and overflow stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busyIn | input | 1 | Converter busy; its falling edge ends a conversion |
| accReq | input | 2 | Register access request: bit 0 = write, bit 1 = read |
| burstLen | input | LEN_W | Number of result words per burst |
| regWrData | input | DATA_W | Word written by a register write |
| dbIn | input | DATA_W | Bus value sampled from the pads |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| dbOut | output | DATA_W | Bus value driven to the pads |
| dbHiZ | output | 1 | 1 = bus driver released |
| chData | output | NUM_CH*DATA_W | Per-channel result words, channel k at bits 16k+15:16k |
| chEnable | output | NUM_CH | Channel covered by the last burst |
| dataValid | output | 1 | One-cycle pulse when a burst has completed |
| overflow | output | 1 | One-cycle pulse on a busy falling edge during a burst |
| regRdData | output | DATA_W | Result of the last register read |
| accDone | output | 1 | One-cycle pulse at the end of a register access |

## Verification
The hardest situations to reach are the collisions: a busy falling edge that lands inside a running burst, and one that lands inside a register access. The bench plays the converter. It places a result on dbIn at each read-strobe fall and stores the word at each write-strobe rise. It times a second busy pulse a few cycles after the first burst has started, and it times another busy pulse to fall during the write strobe. The bench then counts the read strobes, csN rising edges and pulses, to show that no access was lost and that no extra burst was started.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BURST_LO,
    ST_BURST_HI,
    ST_ACC_LO,
    ST_ACC_HI
  } pbusState_e;

  typedef struct packed {
    logic capWord;    // sample dbIn into the indexed channel
    logic capReg;     // sample dbIn into the register read result
    logic latchWr;    // load the write word into the bus output register
    logic burstDone;  // last word of a burst finished
    logic accDone;    // register access finished
    logic ovf;        // busy fell while a burst was active or pending
  } pbusStrobe_t;

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int STROBE_CYC = 2,
  parameter int LEN_W      = $clog2(NUM_CH + 1),
  parameter int IDX_W      = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busyIn,
  input  logic [1:0]       accReq,
  input  logic [LEN_W-1:0] burstLen,
  output logic             csN,
  output logic             rdN,
  output logic             wrN,
  output logic             driveBus,
  output pbusStrobe_t      stb,
  output logic [IDX_W-1:0] wordIdx,
  output logic [LEN_W-1:0] lenQ
);

  localparam int PH_W = $clog2(STROBE_CYC) + 1;

  pbusState_e       state;
  logic             busyQ;
  logic             pend;
  logic             isWr;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] lenClamp;

  logic busyFall;
  logic inBurst;
  logic phEnd;
  logic lastWord;

  assign busyFall = busyQ & ~busyIn;
  assign inBurst  = (state == ST_BURST_LO) || (state == ST_BURST_HI);
  assign phEnd    = (ph == PH_W'(STROBE_CYC - 1));
  assign lastWord = ((LEN_W'(idx) + LEN_W'(1)) == lenQ);
  assign lenClamp = (burstLen > LEN_W'(NUM_CH)) ? LEN_W'(NUM_CH) : burstLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busyQ <= 1'b0;
      pend  <= 1'b0;
      isWr  <= 1'b0;
      ph    <= '0;
      idx   <= '0;
      lenQ  <= '0;
    end else begin
      busyQ <= busyIn;
      if (busyFall && !inBurst && !pend) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          ph <= '0;
          if (pend) begin
            pend <= 1'b0;
            lenQ <= lenClamp;
            idx  <= '0;
            if (lenClamp != '0) state <= ST_BURST_LO;
          end else if (accReq[0]) begin
            isWr  <= 1'b1;
            state <= ST_ACC_LO;
          end else if (accReq[1]) begin
            isWr  <= 1'b0;
            state <= ST_ACC_LO;
          end
        end
        ST_BURST_LO: begin
          if (phEnd) begin
            ph    <= '0;
            state <= ST_BURST_HI;
          end else ph <= ph + PH_W'(1);
        end
        ST_BURST_HI: begin
          if (phEnd) begin
            ph <= '0;
            if (lastWord) state <= ST_IDLE;
            else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_BURST_LO;
            end
          end else ph <= ph + PH_W'(1);
        end
        ST_ACC_LO: begin
          if (phEnd) begin
            ph    <= '0;
            state <= ST_ACC_HI;
          end else ph <= ph + PH_W'(1);
        end
        ST_ACC_HI: begin
          if (phEnd) begin
            ph    <= '0;
            state <= ST_IDLE;
          end else ph <= ph + PH_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.capWord   = (state == ST_BURST_LO) && phEnd;
    stb.capReg    = (state == ST_ACC_LO) && phEnd && !isWr;
    stb.latchWr   = (state == ST_IDLE) && !pend && accReq[0];
    stb.burstDone = (state == ST_BURST_HI) && phEnd && lastWord;
    stb.accDone   = (state == ST_ACC_HI) && phEnd;
    stb.ovf       = busyFall && (inBurst || pend);
  end

  assign csN      = !(inBurst || (state == ST_ACC_LO));
  assign rdN      = !((state == ST_BURST_LO) || ((state == ST_ACC_LO) && !isWr));
  assign wrN      = !((state == ST_ACC_LO) && isWr);
  assign driveBus = (state == ST_ACC_LO) && isWr;
  assign wordIdx  = idx;

endmodule

// File: rtl/pbus_dpath.sv
module pbus_dpath
  import pbus_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(NUM_CH + 1),
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pbusStrobe_t              stb,
  input  logic [IDX_W-1:0]         wordIdx,
  input  logic [LEN_W-1:0]         lenQ,
  input  logic                     driveBus,
  input  logic [DATA_W-1:0]        dbIn,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        dbOut,
  output logic                     dbHiZ,
  output logic [NUM_CH*DATA_W-1:0] chData,
  output logic [NUM_CH-1:0]        chEnable,
  output logic                     dataValid,
  output logic                     overflow,
  output logic [DATA_W-1:0]        regRdData,
  output logic                     accDone
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [DATA_W-1:0] chReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chReg <= '0;
      else if (stb.capWord && (wordIdx == IDX_W'(g))) chReg <= dbIn;
    end
    assign chData[g*DATA_W +: DATA_W] = chReg;
    assign chEnable[g] = (LEN_W'(g) < lenQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbOut     <= '0;
      regRdData <= '0;
      dataValid <= 1'b0;
      overflow  <= 1'b0;
      accDone   <= 1'b0;
    end else begin
      if (stb.latchWr) dbOut <= regWrData;
      if (stb.capReg)  regRdData <= dbIn;
      dataValid <= stb.burstDone;
      overflow  <= stb.ovf;
      accDone   <= stb.accDone;
    end
  end

  assign dbHiZ = ~driveBus;

endmodule

// File: rtl/pbus_adc_ctrl.sv
module pbus_adc_ctrl
  import pbus_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 2,
  parameter int LEN_W      = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busyIn,
  input  logic [1:0]               accReq,
  input  logic [LEN_W-1:0]         burstLen,
  input  logic [DATA_W-1:0]        regWrData,
  input  logic [DATA_W-1:0]        dbIn,
  output logic                     csN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        dbOut,
  output logic                     dbHiZ,
  output logic [NUM_CH*DATA_W-1:0] chData,
  output logic [NUM_CH-1:0]        chEnable,
  output logic                     dataValid,
  output logic                     overflow,
  output logic [DATA_W-1:0]        regRdData,
  output logic                     accDone
);

  localparam int IDX_W = $clog2(NUM_CH);

  pbusStrobe_t      stb;
  logic [IDX_W-1:0] wordIdx;
  logic [LEN_W-1:0] lenQ;
  logic             driveBus;

  pbus_ctrl #(
    .NUM_CH(NUM_CH), .STROBE_CYC(STROBE_CYC), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .accReq(accReq), .burstLen(burstLen),
    .csN(csN), .rdN(rdN), .wrN(wrN), .driveBus(driveBus), .stb(stb),
    .wordIdx(wordIdx), .lenQ(lenQ)
  );

  pbus_dpath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wordIdx(wordIdx), .lenQ(lenQ),
    .driveBus(driveBus), .dbIn(dbIn), .regWrData(regWrData), .dbOut(dbOut),
    .dbHiZ(dbHiZ), .chData(chData), .chEnable(chEnable), .dataValid(dataValid),
    .overflow(overflow), .regRdData(regRdData), .accDone(accDone)
  );

endmodule

// File: rtl/pbus_chk.sv
module pbus_chk (
  input logic clk,
  input logic rstN,
  input logic busyIn,
  input logic csN,
  input logic rdN,
  input logic wrN,
  input logic dbHiZ,
  input logic dataValid,
  input logic overflow
);

  a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !csN);

  a_r8_read_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> dbHiZ);

  a_r7_write_drives_bus: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !dbHiZ);

  a_r5_valid_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> csN);

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  a_r11_ovf_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (!$past(busyIn) && $past(busyIn, 2)));

endmodule

bind pbus_adc_ctrl pbus_chk uChk (
  .clk(clk), .rstN(rstN), .busyIn(busyIn), .csN(csN), .rdN(rdN), .wrN(wrN),
  .dbHiZ(dbHiZ), .dataValid(dataValid), .overflow(overflow)
);

// File: tb/sim_pbus_adc_ctrl.sv
`timescale 1ns/1ps
module sim_pbus_adc_ctrl;

  localparam int NUM_CH = 16;
  localparam int DATA_W = 16;
  localparam int STROBE_CYC = 2;
  localparam int LEN_W = $clog2(NUM_CH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busyIn = 1'b0;
  logic [1:0] accReq = 2'b00;
  logic [LEN_W-1:0] burstLen = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] dbIn = '0;
  logic csN, rdN, wrN, dbHiZ, dataValid, overflow, accDone;
  logic [DATA_W-1:0] dbOut, regRdData;
  logic [NUM_CH*DATA_W-1:0] chData;
  logic [NUM_CH-1:0] chEnable;

  always #2.5 clk = ~clk;

  pbus_adc_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .accReq(accReq), .burstLen(burstLen),
    .regWrData(regWrData), .dbIn(dbIn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .dbOut(dbOut), .dbHiZ(dbHiZ), .chData(chData), .chEnable(chEnable),
    .dataValid(dataValid), .overflow(overflow), .regRdData(regRdData), .accDone(accDone)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // converter model
  bit regMode = 0;
  logic [DATA_W-1:0] resBase = '0;
  int resCnt = 0;
  logic [DATA_W-1:0] devReg = '0;
  logic [DATA_W-1:0] lastWrWord = '0;

  always @(negedge rdN) begin
    #1;
    if (regMode) dbIn = devReg;
    else begin
      dbIn = resBase + DATA_W'(resCnt);
      resCnt++;
    end
  end

  always @(posedge wrN) begin
    devReg = dbOut;
    lastWrWord = dbOut;
  end

  // monitor
  int rdFalls = 0, wrRises = 0, csRises = 0, validCnt = 0, ovfCnt = 0, doneCnt = 0;
  int rdRun = 0, wrRun = 0, lastRdLow = 0, lastWrLow = 0;
  logic prevRd = 1, prevWr = 1, prevCs = 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRd && !rdN) rdFalls++;
      if (!prevWr && wrN) wrRises++;
      if (!prevCs && csN) csRises++;
      if (dataValid) validCnt++;
      if (overflow) ovfCnt++;
      if (accDone) doneCnt++;
      if (!rdN) rdRun++;
      else if (rdRun != 0) begin lastRdLow = rdRun; rdRun = 0; end
      if (!wrN) wrRun++;
      else if (wrRun != 0) begin lastWrLow = wrRun; wrRun = 0; end
    end
    prevRd = rdN; prevWr = wrN; prevCs = csN;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busyPulse();
    busyIn = 1'b1;
    cyc(3);
    busyIn = 1'b0;
  endtask

  task automatic waitValid(input int v0, input string tag);
    int k = 0;
    while (validCnt == v0 && k < 300) begin cyc(1); k++; end
    check(validCnt == v0 + 1, tag, validCnt - v0, 1);
  endtask

  task automatic checkChannels(input int len, input logic [DATA_W-1:0] base, input string tag);
    for (int k = 0; k < len; k++)
      check(chData[k*DATA_W +: DATA_W] == base + DATA_W'(k), tag,
            chData[k*DATA_W +: DATA_W], base + DATA_W'(k));
  endtask

  task automatic t_reset();
    cyc(1);
    check(csN && rdN && wrN, "R1 strobes idle", {csN, rdN, wrN}, 3'b111);
    check(dbHiZ == 1'b1, "R1 bus released", dbHiZ, 1);
    check(!dataValid && !overflow && !accDone, "R1 pulses low",
          {dataValid, overflow, accDone}, 0);
  endtask

  task automatic t_busy_high_only();
    int r0 = rdFalls;
    busyIn = 1'b1;
    cyc(12);
    check(rdFalls == r0, "R2 no read while busy high", rdFalls - r0, 0);
    // release busy; this fall launches a burst of the current length
    burstLen = LEN_W'(2); resBase = 16'h0100; resCnt = 0; regMode = 0;
    busyIn = 1'b0;
    begin
      int v0 = validCnt;
      waitValid(v0, "R2 burst after fall");
    end
  endtask

  task automatic t_burst(input int len, input logic [DATA_W-1:0] base, input string tag);
    int r0 = rdFalls, c0 = csRises, v0 = validCnt;
    int expLen = (len > NUM_CH) ? NUM_CH : len;
    burstLen = LEN_W'(len); resBase = base; resCnt = 0; regMode = 0;
    busyPulse();
    waitValid(v0, {tag, " R5 valid"});
    check(rdFalls - r0 == expLen, {tag, " R4 word count"}, rdFalls - r0, expLen);
    check(csRises - c0 == 1, {tag, " R3 single cs window"}, csRises - c0, 1);
    check(lastRdLow == STROBE_CYC, {tag, " R3 rd low width"}, lastRdLow, STROBE_CYC);
    check(csN == 1'b1, {tag, " R5 cs released"}, csN, 1);
    checkChannels(expLen, base, {tag, " R4 channel data"});
    for (int i = 0; i < NUM_CH; i++)
      check(chEnable[i] == (i < expLen), {tag, " R5 enable"}, chEnable[i], i < expLen);
    cyc(1);
    check(validCnt - v0 == 1, {tag, " R5 single pulse"}, validCnt - v0, 1);
  endtask

  task automatic t_zero_len();
    int r0 = rdFalls, v0 = validCnt;
    burstLen = '0;
    busyPulse();
    cyc(40);
    check(rdFalls == r0, "R6 no reads", rdFalls - r0, 0);
    check(validCnt == v0, "R6 no valid", validCnt - v0, 0);
  endtask

  task automatic t_write(input logic [DATA_W-1:0] val);
    int w0 = wrRises, d0 = doneCnt, r0 = rdFalls;
    regWrData = val;
    accReq = 2'b01;
    cyc(1);
    accReq = 2'b00;
    cyc(12);
    check(wrRises - w0 == 1, "R7 one write strobe", wrRises - w0, 1);
    check(lastWrWord == val, "R7 write word", lastWrWord, val);
    check(lastWrLow == STROBE_CYC, "R7 wr low width", lastWrLow, STROBE_CYC);
    check(doneCnt - d0 == 1, "R7 done pulse", doneCnt - d0, 1);
    check(rdFalls == r0, "R7 no read strobe", rdFalls - r0, 0);
  endtask

  task automatic t_read(input logic [DATA_W-1:0] exp);
    int d0 = doneCnt, w0 = wrRises;
    regMode = 1;
    accReq = 2'b10;
    cyc(1);
    accReq = 2'b00;
    cyc(12);
    regMode = 0;
    check(regRdData == exp, "R8 read data", regRdData, exp);
    check(doneCnt - d0 == 1, "R8 done pulse", doneCnt - d0, 1);
    check(wrRises == w0, "R8 no write strobe", wrRises - w0, 0);
  endtask

  task automatic t_both();
    int w0 = wrRises, r0 = rdFalls;
    regWrData = 16'h5A17;
    accReq = 2'b11;
    cyc(1);
    accReq = 2'b00;
    cyc(12);
    check(wrRises - w0 == 1, "R9 write performed", wrRises - w0, 1);
    check(rdFalls == r0, "R9 read suppressed", rdFalls - r0, 0);
    check(lastWrWord == 16'h5A17, "R9 write word", lastWrWord, 16'h5A17);
  endtask

  task automatic t_req_in_burst();
    int w0 = wrRises, d0 = doneCnt, v0 = validCnt;
    burstLen = LEN_W'(8); resBase = 16'h3000; resCnt = 0; regMode = 0;
    busyPulse();
    cyc(5);
    check(csN == 1'b0, "R10 burst running", csN, 0);
    regWrData = 16'hDEAD;
    accReq = 2'b01;
    cyc(1);
    accReq = 2'b00;
    waitValid(v0, "R10 burst valid");
    cyc(20);
    check(wrRises == w0, "R10 write ignored", wrRises - w0, 0);
    check(doneCnt == d0, "R10 no done", doneCnt - d0, 0);
    checkChannels(8, 16'h3000, "R10 data intact");
  endtask

  task automatic t_overflow();
    int r0 = rdFalls, o0 = ovfCnt, v0 = validCnt;
    burstLen = LEN_W'(6); resBase = 16'h4400; resCnt = 0; regMode = 0;
    busyPulse();
    cyc(4);
    busyPulse();
    waitValid(v0, "R11 burst valid");
    check(ovfCnt - o0 == 1, "R11 overflow pulse", ovfCnt - o0, 1);
    checkChannels(6, 16'h4400, "R11 order kept");
    cyc(60);
    check(rdFalls - r0 == 6, "R11 no second burst", rdFalls - r0, 6);
    check(validCnt - v0 == 1, "R11 one valid", validCnt - v0, 1);
  endtask

  task automatic t_fall_in_access();
    int w0 = wrRises, o0 = ovfCnt, v0 = validCnt, d0 = doneCnt;
    burstLen = LEN_W'(4); resBase = 16'h7700; resCnt = 0; regMode = 0;
    regWrData = 16'hC0DE;
    busyIn = 1'b1;
    accReq = 2'b01;
    cyc(1);
    accReq = 2'b00;
    check(wrN == 1'b0, "R12 write in progress", wrN, 0);
    busyIn = 1'b0;
    waitValid(v0, "R12 burst after access");
    check(wrRises - w0 == 1, "R12 write completed", wrRises - w0, 1);
    check(lastWrWord == 16'hC0DE, "R12 write word", lastWrWord, 16'hC0DE);
    check(doneCnt - d0 == 1, "R12 done", doneCnt - d0, 1);
    check(ovfCnt == o0, "R12 no overflow", ovfCnt - o0, 0);
    checkChannels(4, 16'h7700, "R12 burst data");
  endtask

  initial begin
    rstN = 1'b0;
    cyc(4);
    t_reset();
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_busy_high_only();
    t_burst(2, 16'h1000, "pairs2");
    t_burst(16, 16'h2000, "full");
    t_burst(20, 16'h2800, "clamped");
    t_burst(5, 16'h0A00, "odd");
    t_zero_len();
    t_write(16'hA5C3);
    t_read(16'hA5C3);
    t_both();
    t_req_in_burst();
    t_overflow();
    t_fall_in_access();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule